// File: doc/BRIEF.md
# Four-Phase Non-Overlapping Clock Generator

This block turns one fast master clock into four mutually exclusive phase signals for a switched-capacitor modulator. The four phases are sample, discharge, transfer and clear. The discharge phase empties the sampling capacitor between sampling and charge transfer, and the clear phase does the same between transfer and the next sample. A counter times every interval, so a guard gap of a chosen number of all-low master-clock cycles separates each phase edge from the next one. This gap replaces the usual chain of delay gates.

Each phase has its own registered output and also a registered complement for driving switches of the opposite polarity. Each complement breaks before its phase makes, and makes only after its phase has broken. When the block is held in reset or disabled, every phase is low. When it is released, the sequence always starts at the beginning of the sample phase with its full width.

Top module: `fpc_four_phase_gen`

## Requirements
- R1: In every cycle at most one of the four phase outputs is high.
- R2: Phase bits are ph_o[0] sample, ph_o[1] discharge, ph_o[2] transfer and ph_o[3] clear. They rise in the cyclic order 0, 1, 2, 3, 0, and the first rise after reset or enable is ph_o[0].
- R3: Each phase stays high for exactly its parameter width: SAMP_CYC, DIS_CYC, XFER_CYC and CLR_CYC (defaults 4, 2, 4, 2) consecutive cycles.
- R4: Between the fall of one phase and the rise of the next there are exactly G cycles with all phases low. G is the value of dead_cyc in the last cycle of the earlier phase, and a value of 0 is treated as 1, so G runs from 1 to 7.
- R5: While dead_cyc is held constant, ph_o[0] rises every SAMP_CYC+DIS_CYC+XFER_CYC+CLR_CYC+4G cycles.
- R6: ph_n_o[k] is never high together with ph_o[k]. It is low in the cycle before ph_o[k] rises and in the cycle after ph_o[k] falls. Once every phase has been low for three cycles, all four complements are high.
- R7: While rst_n is low, ph_o is 0 and ph_n_o is 4'hF, without waiting for a clock edge. After rst_n is released with en high, ph_o[0] goes high after the fourth rising edge and is still low after the third.
- R8: When en is low at two consecutive rising edges, all phases are low after the second edge and remain low for as long as en stays low.
- R9: When en rises while the block is idle, ph_o stays 0 after the first rising edge that samples en high and becomes 4'b0001 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low forces all phases low |
| dead_cyc | input | DEAD_W (3) | Guard gap length in cycles, 0 treated as 1 |
| ph_o | output | 4 | Phase outputs: sample, discharge, transfer, clear |
| ph_n_o | output | 4 | Break-before-make complements of ph_o |

## Verification
A phase output lags the sequencer state by one register. A change of en therefore shows on ph_o two rising edges after it is driven, and a reset release shows after four edges, because two of them pass through the reset synchronizer. The complements lead each phase rise by one cycle and trail each phase fall by one cycle. The bench drives its inputs at the falling edge and samples there, and each directed check waits exactly the number of edges worked out above. The per-cycle monitor measures widths, gaps, order and period only across runs that start from idle, so a run that is cut short is never scored against a full width.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int NUM_PH = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAMP,
    ST_G0,
    ST_DIS,
    ST_G1,
    ST_XFER,
    ST_G2,
    ST_CLR,
    ST_G3
  } seq_st_t;

  function automatic logic [2:0] clamp_gap(input logic [2:0] g);
    return (g == 3'd0) ? 3'd1 : g;
  endfunction

endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/fpc_sequencer.sv
module fpc_sequencer
  import fpc_pkg::*;
#(
  parameter int SAMP_CYC = 4,
  parameter int DIS_CYC  = 2,
  parameter int XFER_CYC = 4,
  parameter int CLR_CYC  = 2,
  parameter int DEAD_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DEAD_W-1:0] dead_cyc,
  output logic [NUM_PH-1:0] cur_act,
  output logic [NUM_PH-1:0] nxt_act
);

  localparam int MAX_PH = (SAMP_CYC > DIS_CYC ? SAMP_CYC : DIS_CYC) >
                          (XFER_CYC > CLR_CYC ? XFER_CYC : CLR_CYC) ?
                          (SAMP_CYC > DIS_CYC ? SAMP_CYC : DIS_CYC) :
                          (XFER_CYC > CLR_CYC ? XFER_CYC : CLR_CYC);
  localparam int MAX_GAP = 1 << DEAD_W;
  localparam int MAX_ALL = MAX_PH > MAX_GAP ? MAX_PH : MAX_GAP;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  localparam logic [CNT_W-1:0] SAMP_LD = CNT_W'(SAMP_CYC - 1);
  localparam logic [CNT_W-1:0] DIS_LD  = CNT_W'(DIS_CYC - 1);
  localparam logic [CNT_W-1:0] XFER_LD = CNT_W'(XFER_CYC - 1);
  localparam logic [CNT_W-1:0] CLR_LD  = CNT_W'(CLR_CYC - 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  seq_st_t          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] gap_ld;
  logic             cnt_zero;

  always_comb begin
    gap_ld = {{(CNT_W-3){1'b0}}, clamp_gap(dead_cyc[2:0])} - ONE;
  end

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!en) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d  = ST_SAMP;
          cnt_d = SAMP_LD;
        end
        ST_SAMP: begin
          if (cnt_zero) begin
            st_d  = ST_G0;
            cnt_d = gap_ld;
          end else cnt_d = cnt_q - ONE;
        end
        ST_G0: begin
          if (cnt_zero) begin
            st_d  = ST_DIS;
            cnt_d = DIS_LD;
          end else cnt_d = cnt_q - ONE;
        end
        ST_DIS: begin
          if (cnt_zero) begin
            st_d  = ST_G1;
            cnt_d = gap_ld;
          end else cnt_d = cnt_q - ONE;
        end
        ST_G1: begin
          if (cnt_zero) begin
            st_d  = ST_XFER;
            cnt_d = XFER_LD;
          end else cnt_d = cnt_q - ONE;
        end
        ST_XFER: begin
          if (cnt_zero) begin
            st_d  = ST_G2;
            cnt_d = gap_ld;
          end else cnt_d = cnt_q - ONE;
        end
        ST_G2: begin
          if (cnt_zero) begin
            st_d  = ST_CLR;
            cnt_d = CLR_LD;
          end else cnt_d = cnt_q - ONE;
        end
        ST_CLR: begin
          if (cnt_zero) begin
            st_d  = ST_G3;
            cnt_d = gap_ld;
          end else cnt_d = cnt_q - ONE;
        end
        ST_G3: begin
          if (cnt_zero) begin
            st_d  = ST_SAMP;
            cnt_d = SAMP_LD;
          end else cnt_d = cnt_q - ONE;
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    cur_act = {st_q == ST_CLR, st_q == ST_XFER, st_q == ST_DIS, st_q == ST_SAMP};
    nxt_act = {st_d == ST_CLR, st_d == ST_XFER, st_d == ST_DIS, st_d == ST_SAMP};
  end

endmodule

// File: rtl/fpc_phase_out.sv
module fpc_phase_out
  import fpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] cur_act,
  input  logic [NUM_PH-1:0] nxt_act,
  output logic [NUM_PH-1:0] ph_q,
  output logic [NUM_PH-1:0] nph_q
);

  for (genvar k = 0; k < NUM_PH; k++) begin : g_drv
    logic ph_d;
    logic nph_d;

    always_comb begin
      ph_d  = cur_act[k];
      nph_d = ~(nxt_act[k] | cur_act[k] | ph_q[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ph_q[k]  <= 1'b0;
        nph_q[k] <= 1'b1;
      end else begin
        ph_q[k]  <= ph_d;
        nph_q[k] <= nph_d;
      end
    end
  end

endmodule

// File: rtl/fpc_four_phase_gen.sv
module fpc_four_phase_gen
  import fpc_pkg::*;
#(
  parameter int SAMP_CYC = 4,
  parameter int DIS_CYC  = 2,
  parameter int XFER_CYC = 4,
  parameter int CLR_CYC  = 2,
  parameter int DEAD_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DEAD_W-1:0] dead_cyc,
  output logic [3:0]        ph_o,
  output logic [3:0]        ph_n_o
);

  logic              rst_n_i;
  logic [NUM_PH-1:0] cur_act;
  logic [NUM_PH-1:0] nxt_act;

  fpc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  fpc_sequencer #(
    .SAMP_CYC (SAMP_CYC),
    .DIS_CYC  (DIS_CYC),
    .XFER_CYC (XFER_CYC),
    .CLR_CYC  (CLR_CYC),
    .DEAD_W   (DEAD_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .en       (en),
    .dead_cyc (dead_cyc),
    .cur_act  (cur_act),
    .nxt_act  (nxt_act)
  );

  fpc_phase_out u_out (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .cur_act (cur_act),
    .nxt_act (nxt_act),
    .ph_q    (ph_o),
    .nph_q   (ph_n_o)
  );

endmodule

// File: rtl/fpc_four_phase_chk.sv
module fpc_four_phase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] ph,
  input logic [3:0] nph
);

  logic [1:0] last_q;
  logic [1:0] idx;

  always_comb begin
    idx = 2'd0;
    for (int i = 0; i < 4; i++) if (ph[i]) idx = 2'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 2'd3;
    else if (ph != 4'd0) last_q <= idx;
  end

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ph)); // R1

  AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (ph & nph) == 4'd0); // R6

  AST_NPH_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph & ~$past(ph)) & $past(nph)) == 4'd0); // R6

  AST_NPH_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ph & $past(ph)) & nph) == 4'd0); // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en) && !$past(en, 2)) |-> (ph == 4'd0)); // R8

  for (genvar k = 1; k < 4; k++) begin : g_ord
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph[k]) |-> (last_q == 2'(k - 1))); // R2
  end

endmodule

bind fpc_four_phase_gen fpc_four_phase_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .ph    (ph_o),
  .nph   (ph_n_o)
);

// File: tb/fpc_four_phase_gen_test.sv
`timescale 1ns/1ps
module fpc_four_phase_gen_test;

  localparam int SAMP = 4, DIS = 2, XFER = 4, CLR = 2;
  localparam int PW[4] = '{SAMP, DIS, XFER, CLR};
  localparam int NROW = 6;
  localparam logic [2:0] GAP_IN[NROW]  = '{3'd1, 3'd3, 3'd7, 3'd0, 3'd5, 3'd2};
  localparam int         GAP_EXP[NROW] = '{1, 3, 7, 1, 5, 2};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [2:0] dead_cyc;
  logic [3:0] ph_o, ph_n_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  fpc_four_phase_gen #(.SAMP_CYC(SAMP), .DIS_CYC(DIS), .XFER_CYC(XFER), .CLR_CYC(CLR), .DEAD_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .dead_cyc(dead_cyc), .ph_o(ph_o), .ph_n_o(ph_n_o)
  );

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // per-cycle monitor
  bit         chk_on = 1'b0;
  int         exp_gap = 1;
  logic [3:0] prev_ph = 4'd0, prev_nph = 4'hF;
  int         run_len[4];
  int         gap_len = 0;
  bit         fall_seen = 1'b0;
  int         last_fall = 0;
  int         cyc = 0;
  int         ph0_cyc = 0;
  bit         ph0_seen = 1'b0;
  int         ph0_rises = 0;

  always @(negedge clk) begin
    logic [3:0] rose, fell;
    cyc++;
    rose = ph_o & ~prev_ph;
    fell = ~ph_o & prev_ph;
    if (chk_on) begin
      chk("R1 at most one phase", $countones(ph_o) <= 1, int'(ph_o), 0);
      chk("R6 phase/complement exclusive", (ph_o & ph_n_o) == 4'd0, int'(ph_o & ph_n_o), 0);
      for (int k = 0; k < 4; k++) begin
        if (rose[k]) chk("R6 complement low before rise", prev_nph[k] == 1'b0, int'(prev_nph[k]), 0);
        if (fell[k]) chk("R6 complement low after fall", ph_n_o[k] == 1'b0, int'(ph_n_o[k]), 0);
        if (ph_o[k]) run_len[k]++;
        else if (fell[k]) begin
          chk("R3 phase width", run_len[k] == PW[k], run_len[k], PW[k]);
          run_len[k] = 0;
        end
      end
      if (ph_o == 4'd0) begin
        if (fell != 4'd0) gap_len = 1;
        else if (fall_seen) gap_len++;
      end
      for (int k = 0; k < 4; k++) begin
        if (fell[k]) begin
          fall_seen = 1'b1;
          last_fall = k;
        end
        if (rose[k]) begin
          if (fall_seen) begin
            chk("R4 guard gap", gap_len == exp_gap, gap_len, exp_gap);
            chk("R2 phase order", k == (last_fall + 1) % 4, k, (last_fall + 1) % 4);
          end else begin
            chk("R2 first phase is sample", k == 0, k, 0);
          end
        end
      end
      if (rose[0]) begin
        if (ph0_seen)
          chk("R5 period", (cyc - ph0_cyc) == SAMP + DIS + XFER + CLR + 4 * exp_gap,
              cyc - ph0_cyc, SAMP + DIS + XFER + CLR + 4 * exp_gap);
        ph0_seen = 1'b1;
        ph0_cyc  = cyc;
        ph0_rises++;
      end
    end
    prev_ph  = ph_o;
    prev_nph = ph_n_o;
  end

  task automatic stop_run();
    chk_on = 1'b0;
    en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 phases low when disabled", ph_o == 4'd0, int'(ph_o), 0);
    chk("R6 complements high when idle", ph_n_o == 4'hF, int'(ph_n_o), 15);
  endtask

  task automatic start_run(input logic [2:0] g, input int eg);
    dead_cyc  = g;
    exp_gap   = eg;
    fall_seen = 1'b0;
    ph0_seen  = 1'b0;
    ph0_rises = 0;
    gap_len   = 0;
    for (int k = 0; k < 4; k++) run_len[k] = 0;
    chk_on = 1'b1;
    en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    en = 1'b1;
    dead_cyc = 3'd2;
    #12;
    chk("R7 reset phases low", ph_o == 4'd0, int'(ph_o), 0);
    chk("R7 reset complements high", ph_n_o == 4'hF, int'(ph_n_o), 15);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 still low after third edge", ph_o == 4'd0, int'(ph_o), 0);
    chk("R6 complement leads after reset", ph_n_o[0] == 1'b0, int'(ph_n_o[0]), 0);
    @(negedge clk);
    chk("R7 sample phase after fourth edge", ph_o == 4'b0001, int'(ph_o), 1);
    repeat (30) @(negedge clk);

    // table walk over guard settings
    for (int r = 0; r < NROW; r++) begin
      stop_run();
      start_run(GAP_IN[r], GAP_EXP[r]);
      @(negedge clk);
      chk("R9 low after first enabled edge", ph_o == 4'd0, int'(ph_o), 0);
      @(negedge clk);
      chk("R9 sample phase after second edge", ph_o == 4'b0001, int'(ph_o), 1);
      repeat (3 * (SAMP + DIS + XFER + CLR + 4 * GAP_EXP[r]) + 6) @(negedge clk);
      chk("R5 at least three periods seen", ph0_rises >= 3, ph0_rises, 3);
    end

    // disable in the middle of the transfer phase
    stop_run();
    start_run(3'd3, 3);
    while (ph_o[2] !== 1'b1) @(negedge clk);
    chk_on = 1'b0;
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 phases low two edges after disable", ph_o == 4'd0, int'(ph_o), 0);
    @(negedge clk);
    chk("R6 complements high after idle", ph_n_o == 4'hF, int'(ph_n_o), 15);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R8 phases stay low", ph_o == 4'd0, int'(ph_o), 0);
    end
    start_run(3'd4, 4);
    repeat (2 * (SAMP + DIS + XFER + CLR + 16) + 4) @(negedge clk);

    // asynchronous reset mid-run
    chk_on = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    chk("R7 async reset clears phases", ph_o == 4'd0, int'(ph_o), 0);
    chk("R7 async reset sets complements", ph_n_o == 4'hF, int'(ph_n_o), 15);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    done = 1'b1;
    summary();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

endmodule